// File: doc/BRIEF.md
# Banked Register File with Status Word

This block is the register store of a small 8-bit microcontroller core. It keeps four banks of eight byte-wide working registers. Two bits of the status word choose which bank the register-code port addresses. Any byte can be read or written alone. Adjacent even/odd bytes also form 16-bit pairs. The same 32 bytes are reachable through a byte-wide memory-mapped port that indexes the whole area directly. In that view the banks appear in reversed order: bank 0 occupies the top eight bytes.

The block also holds the status word, an even-only 16-bit stack pointer, two segment bytes and a mode byte. From the zero and carry flags it evaluates the eight branch conditions the core needs. Reads through both ports are combinational. All writes take effect on the rising clock edge. A write to an undefined register code, or an odd stack-pointer value, is flagged for one cycle.

Top module: `regbank_file`

## Requirements
- R1: After reset, every one of the 32 area bytes reads 0x11. The status word reads 0x06, the stack pointer 0x0000, the data segment byte 0x0F, and the code segment and mode bytes 0x00.
- R2: Register codes 1 to 8 address byte slots 0 to 7 of the active bank. The active bank number is 2*status[5] + status[3]. Slot s of bank b is area offset (3-b)*8 + s.
- R3: Register codes 9 to 12 address pair p = code-9. The pair reads as slot 2p+1 * 256 + slot 2p. A pair write stores bits 7:0 in slot 2p and bits 15:8 in slot 2p+1.
- R4: A bank change written to the status word governs register-code accesses from the very next cycle.
- R5: Code 13 is the stack pointer. A write clears bit 0. An odd written value raises spOddWarn for the one cycle after the write.
- R6: A write with code 0 or any code from 18 to 31 changes no state. It raises wrBadCode for the one cycle after the write.
- R7: Reading code 0, or any undefined code, returns 0.
- R8: The memory-mapped port reads area byte memAddr combinationally and writes it at the clock edge.
- R9: When the register port and the memory port write the same area byte in one cycle, the register port's value is stored.
- R10: condTrue follows condSel: 0 condVal!=0, 1 condVal==0, 2 carry, 3 not carry, 4 zero, 5 not zero, 6 neither zero nor carry, 7 zero or carry. Zero is status bit 6 and carry is status bit 0.
- R11: Codes 14 (status), 15 (code segment), 16 (data segment) and 17 (mode) store wrData[7:0]. They read back with bits 15:8 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdCode | input | 5 | Register code for the read port |
| rdData | output | 16 | Combinational read data |
| wrEn | input | 1 | Register-port write enable |
| wrCode | input | 5 | Register code for the write port |
| wrData | input | 16 | Register-port write data |
| wrBadCode | output | 1 | Pulse: the previous write used an undefined code |
| spOddWarn | output | 1 | Pulse: the previous stack-pointer write was odd |
| memAddr | input | 5 | Byte offset into the 32-byte register area |
| memRdData | output | 8 | Combinational area byte at memAddr |
| memWe | input | 1 | Memory-port write enable |
| memWrData | input | 8 | Memory-port write data |
| condSel | input | 3 | Branch condition selector |
| condVal | input | 16 | Value tested by the true/false conditions |
| condTrue | output | 1 | Condition result |

## Verification
Some properties are checked on every cycle. The write decoder never fires two targets at once. A status write moves the bank on the next cycle. Odd stack writes and undefined codes raise their one-cycle flags. Code 0 reads zero, and the stack pointer never reads odd. A same-byte collision leaves the register port's data in place. The bank-to-offset mapping, pair byte order, reset contents, the condition table and the proof that a rejected write disturbs nothing come only from the bench. It sweeps all banks, slots, pairs, area offsets, flag combinations and undefined codes against its own model of the area.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int CODE_W     = 5;
  localparam int DATA_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int BANK_CNT   = 4;
  localparam int BANK_BYTES = 8;
  localparam int AREA_BYTES = BANK_CNT * BANK_BYTES;
  localparam int AREA_AW    = $clog2(AREA_BYTES);
  localparam int SLOT_W     = $clog2(BANK_BYTES);
  localparam int PAIR_W     = $clog2(BANK_BYTES / 2);
  localparam int BANK_W     = $clog2(BANK_CNT);

  // register codes
  localparam logic [CODE_W-1:0] CODE_NONE       = 5'd0;
  localparam logic [CODE_W-1:0] CODE_BYTE_FIRST = 5'd1;
  localparam logic [CODE_W-1:0] CODE_BYTE_LAST  = 5'd8;
  localparam logic [CODE_W-1:0] CODE_PAIR_FIRST = 5'd9;
  localparam logic [CODE_W-1:0] CODE_PAIR_LAST  = 5'd12;
  localparam logic [CODE_W-1:0] CODE_STK        = 5'd13;
  localparam logic [CODE_W-1:0] CODE_STAT       = 5'd14;
  localparam logic [CODE_W-1:0] CODE_CSEG       = 5'd15;
  localparam logic [CODE_W-1:0] CODE_DSEG       = 5'd16;
  localparam logic [CODE_W-1:0] CODE_MODE       = 5'd17;

  // status word bit positions
  localparam int ST_ZERO    = 6;
  localparam int ST_BANK_HI = 5;
  localparam int ST_BANK_LO = 3;
  localparam int ST_CARRY   = 0;

  typedef enum logic [2:0] {
    COND_TRUE_VAL  = 3'd0,
    COND_FALSE_VAL = 3'd1,
    COND_CARRY     = 3'd2,
    COND_NO_CARRY  = 3'd3,
    COND_ZERO      = 3'd4,
    COND_NOT_ZERO  = 3'd5,
    COND_ABOVE     = 3'd6,
    COND_NOT_ABOVE = 3'd7
  } cond_e;

  typedef struct packed {
    logic              byteWe;
    logic              pairWe;
    logic [SLOT_W-1:0] slot;
    logic [PAIR_W-1:0] pair;
    logic              stkWe;
    logic              statWe;
    logic              csegWe;
    logic              dsegWe;
    logic              modeWe;
    logic              badCode;
  } wr_strobe_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrCode,
  output wr_strobe_t        strobe
);

  always_comb begin
    strobe = '0;
    strobe.slot = SLOT_W'(wrCode - CODE_BYTE_FIRST);
    strobe.pair = PAIR_W'(wrCode - CODE_PAIR_FIRST);
    if (wrEn) begin
      if (wrCode >= CODE_BYTE_FIRST && wrCode <= CODE_BYTE_LAST)
        strobe.byteWe = 1'b1;
      else if (wrCode >= CODE_PAIR_FIRST && wrCode <= CODE_PAIR_LAST)
        strobe.pairWe = 1'b1;
      else begin
        case (wrCode)
          CODE_STK:  strobe.stkWe  = 1'b1;
          CODE_STAT: strobe.statWe = 1'b1;
          CODE_CSEG: strobe.csegWe = 1'b1;
          CODE_DSEG: strobe.dsegWe = 1'b1;
          CODE_MODE: strobe.modeWe = 1'b1;
          default:   strobe.badCode = 1'b1;
        endcase
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.byteWe, strobe.pairWe, strobe.stkWe, strobe.statWe,
              strobe.csegWe, strobe.dsegWe, strobe.modeWe, strobe.badCode})); // R6

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_BYTE = 8'h11,
  parameter logic [BYTE_W-1:0] RST_STAT = 8'h06,
  parameter logic [BYTE_W-1:0] RST_DSEG = 8'h0F
) (
  input  logic               clk,
  input  logic               rstN,
  input  wr_strobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [CODE_W-1:0]  rdCode,
  output logic [DATA_W-1:0]  rdData,
  input  logic [AREA_AW-1:0] memAddr,
  output logic [BYTE_W-1:0]  memRdData,
  input  logic               memWe,
  input  logic [BYTE_W-1:0]  memWrData,
  input  logic [2:0]         condSel,
  input  logic [DATA_W-1:0]  condVal,
  output logic               condTrue,
  output logic               wrBadCode,
  output logic               spOddWarn
);

  logic [BYTE_W-1:0] area [AREA_BYTES];
  logic [BYTE_W-1:0] status, cseg, dseg, modeByte;
  logic [DATA_W-1:0] stkPtr;
  logic [BANK_W-1:0] bank;
  logic [AREA_AW-1:0] wrLo, wrHi;
  logic [SLOT_W-1:0] rdSlot;
  logic [PAIR_W-1:0] rdPair;
  logic zeroF, carryF;

  assign bank = {status[ST_BANK_HI], status[ST_BANK_LO]};

  // bank b lives at offset (3-b)*8, i.e. upper index bits are ~b
  always_comb begin
    wrLo = strobe.pairWe ? {~bank, strobe.pair, 1'b0} : {~bank, strobe.slot};
    wrHi = {~bank, strobe.pair, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < AREA_BYTES; i++) area[i] <= RST_BYTE;
      status    <= RST_STAT;
      cseg      <= '0;
      dseg      <= RST_DSEG;
      modeByte  <= '0;
      stkPtr    <= '0;
      wrBadCode <= 1'b0;
      spOddWarn <= 1'b0;
    end else begin
      for (int i = 0; i < AREA_BYTES; i++) begin
        if ((strobe.byteWe || strobe.pairWe) && AREA_AW'(i) == wrLo)
          area[i] <= wrData[BYTE_W-1:0];
        else if (strobe.pairWe && AREA_AW'(i) == wrHi)
          area[i] <= wrData[DATA_W-1:BYTE_W];
        else if (memWe && AREA_AW'(i) == memAddr)
          area[i] <= memWrData;
      end
      if (strobe.stkWe)  stkPtr   <= {wrData[DATA_W-1:1], 1'b0};
      if (strobe.statWe) status   <= wrData[BYTE_W-1:0];
      if (strobe.csegWe) cseg     <= wrData[BYTE_W-1:0];
      if (strobe.dsegWe) dseg     <= wrData[BYTE_W-1:0];
      if (strobe.modeWe) modeByte <= wrData[BYTE_W-1:0];
      wrBadCode <= strobe.badCode;
      spOddWarn <= strobe.stkWe & wrData[0];
    end
  end

  // combinational read port
  always_comb begin
    rdSlot = SLOT_W'(rdCode - CODE_BYTE_FIRST);
    rdPair = PAIR_W'(rdCode - CODE_PAIR_FIRST);
    rdData = '0;
    if (rdCode >= CODE_BYTE_FIRST && rdCode <= CODE_BYTE_LAST)
      rdData = {8'h00, area[{~bank, rdSlot}]};
    else if (rdCode >= CODE_PAIR_FIRST && rdCode <= CODE_PAIR_LAST)
      rdData = {area[{~bank, rdPair, 1'b1}], area[{~bank, rdPair, 1'b0}]};
    else begin
      case (rdCode)
        CODE_STK:  rdData = stkPtr;
        CODE_STAT: rdData = {8'h00, status};
        CODE_CSEG: rdData = {8'h00, cseg};
        CODE_DSEG: rdData = {8'h00, dseg};
        CODE_MODE: rdData = {8'h00, modeByte};
        default:   rdData = '0;
      endcase
    end
  end

  assign memRdData = area[memAddr];

  // branch conditions
  assign zeroF  = status[ST_ZERO];
  assign carryF = status[ST_CARRY];
  always_comb begin
    case (cond_e'(condSel))
      COND_TRUE_VAL:  condTrue = (condVal != '0);
      COND_FALSE_VAL: condTrue = (condVal == '0);
      COND_CARRY:     condTrue = carryF;
      COND_NO_CARRY:  condTrue = !carryF;
      COND_ZERO:      condTrue = zeroF;
      COND_NOT_ZERO:  condTrue = !zeroF;
      COND_ABOVE:     condTrue = !(zeroF | carryF);
      default:        condTrue = zeroF | carryF;
    endcase
  end

  AST_BANK_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.statWe |=> bank == {$past(wrData[ST_BANK_HI]), $past(wrData[ST_BANK_LO])}); // R4
  AST_SP_WARN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stkWe && wrData[0]) |=> spOddWarn); // R5
  AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (rdCode == CODE_STK) |-> !rdData[0]); // R5
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdCode == CODE_NONE) |-> rdData == '0); // R7
  AST_REG_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && strobe.byteWe && memAddr == wrLo)
      |=> area[$past(memAddr)] == $past(wrData[BYTE_W-1:0])); // R9

endmodule

// File: rtl/regbank_file.sv
module regbank_file
  import regbank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [4:0]   rdCode,
  output logic [15:0]  rdData,
  input  logic         wrEn,
  input  logic [4:0]   wrCode,
  input  logic [15:0]  wrData,
  output logic         wrBadCode,
  output logic         spOddWarn,
  input  logic [4:0]   memAddr,
  output logic [7:0]   memRdData,
  input  logic         memWe,
  input  logic [7:0]   memWrData,
  input  logic [2:0]   condSel,
  input  logic [15:0]  condVal,
  output logic         condTrue
);

  wr_strobe_t strobe;

  regbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode), .strobe(strobe)
  );

  regbank_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdCode(rdCode), .rdData(rdData),
    .memAddr(memAddr), .memRdData(memRdData), .memWe(memWe), .memWrData(memWrData),
    .condSel(condSel), .condVal(condVal), .condTrue(condTrue),
    .wrBadCode(wrBadCode), .spOddWarn(spOddWarn)
  );

  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrCode == CODE_NONE || wrCode > CODE_MODE)) |=> wrBadCode); // R6
  AST_BAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !wrBadCode && !spOddWarn); // R6

endmodule

// File: tb/regbank_file_test.sv
module regbank_file_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] rdCode = '0;
  logic [15:0] rdData;
  logic wrEn = 1'b0;
  logic [4:0] wrCode = '0;
  logic [15:0] wrData = '0;
  logic wrBadCode, spOddWarn;
  logic [4:0] memAddr = '0;
  logic [7:0] memRdData;
  logic memWe = 1'b0;
  logic [7:0] memWrData = '0;
  logic [2:0] condSel = '0;
  logic [15:0] condVal = '0;
  logic condTrue;

  int checks = 0;
  int errors = 0;
  logic gotBad, gotWarn;

  // bench model
  logic [7:0] mArea [32];
  logic [7:0] mStat;

  always #10 clk = ~clk;

  regbank_file uut (
    .clk(clk), .rstN(rstN), .rdCode(rdCode), .rdData(rdData),
    .wrEn(wrEn), .wrCode(wrCode), .wrData(wrData),
    .wrBadCode(wrBadCode), .spOddWarn(spOddWarn),
    .memAddr(memAddr), .memRdData(memRdData), .memWe(memWe), .memWrData(memWrData),
    .condSel(condSel), .condVal(condVal), .condTrue(condTrue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int bankOf(input logic [7:0] st);
    return 2 * st[5] + st[3];
  endfunction

  function automatic int offOf(input int b, input int s);
    return (3 - b) * 8 + s;
  endfunction

  // register-port write; the model follows R2/R3/R11
  task automatic regWrite(input logic [4:0] code, input logic [15:0] data);
    int b;
    b = bankOf(mStat);
    @(negedge clk);
    wrEn = 1'b1; wrCode = code; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    gotBad = wrBadCode; gotWarn = spOddWarn;
    if (code >= 1 && code <= 8) mArea[offOf(b, code - 1)] = data[7:0];
    else if (code >= 9 && code <= 12) begin
      mArea[offOf(b, 2 * (code - 9))] = data[7:0];
      mArea[offOf(b, 2 * (code - 9) + 1)] = data[15:8];
    end else if (code == 14) mStat = data[7:0];
  endtask

  task automatic memWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    memWe = 1'b1; memAddr = 5'(addr); memWrData = data;
    @(negedge clk);
    memWe = 1'b0;
    mArea[addr] = data;
  endtask

  task automatic readCode(input logic [4:0] code, output logic [15:0] val);
    rdCode = code; #1; val = rdData;
  endtask

  task automatic checkArea(input string tag);
    for (int i = 0; i < 32; i++) begin
      memAddr = 5'(i); #1;
      check(memRdData == mArea[i], tag, int'(memRdData), int'(mArea[i]));
    end
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 32; i++) mArea[i] = 8'h11;
    mStat = 8'h06;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset contents
    checkArea("R1 area reset");
    readCode(5'd14, v); check(v == 16'h0006, "R1 status", v, 16'h0006);
    readCode(5'd13, v); check(v == 16'h0000, "R1 stack", v, 0);
    readCode(5'd15, v); check(v == 16'h0000, "R1 cseg", v, 0);
    readCode(5'd16, v); check(v == 16'h000F, "R1 dseg", v, 16'h000F);
    readCode(5'd17, v); check(v == 16'h0000, "R1 mode", v, 0);
    check(wrBadCode == 1'b0 && spOddWarn == 1'b0, "R1 flags", {wrBadCode, spOddWarn}, 0);

    // R7: none / undefined reads
    readCode(5'd0, v); check(v == 0, "R7 none read", v, 0);
    for (int c = 18; c < 32; c++) begin
      readCode(5'(c), v); check(v == 0, "R7 undefined read", v, 0);
    end

    // R2 / R4: byte sweep over all banks; first byte write follows status write directly
    for (int b = 0; b < 4; b++) begin
      regWrite(5'd14, {8'h00, 2'b00, 1'(b >> 1), 1'b0, 1'(b & 1), 3'b000});
      readCode(5'd1, v);
      check(v == {8'h00, mArea[offOf(b, 0)]}, "R4 bank next cycle", v, mArea[offOf(b, 0)]);
      for (int s = 0; s < 8; s++) regWrite(5'(1 + s), 16'hFF00 | 16'(8'h40 + b * 8 + s));
      for (int s = 0; s < 8; s++) begin
        readCode(5'(1 + s), v);
        check(v == 16'(8'h40 + b * 8 + s), "R2 byte read", v, 8'h40 + b * 8 + s);
      end
    end
    checkArea("R2 area layout");
    for (int b = 0; b < 4; b++) begin
      memAddr = 5'(offOf(b, 5)); #1;
      check(memRdData == 8'(8'h40 + b * 8 + 5), "R2 reversed order", memRdData, 8'h40 + b * 8 + 5);
    end

    // R3: pair sweep
    for (int b = 0; b < 4; b++) begin
      regWrite(5'd14, {8'h00, 2'b00, 1'(b >> 1), 1'b0, 1'(b & 1), 3'b000});
      for (int p = 0; p < 4; p++) regWrite(5'(9 + p), 16'(16'hA000 + b * 16'h0110 + p * 16'h1003));
      for (int p = 0; p < 4; p++) begin
        readCode(5'(9 + p), v);
        check(v == 16'(16'hA000 + b * 16'h0110 + p * 16'h1003), "R3 pair read", v,
              16'hA000 + b * 16'h0110 + p * 16'h1003);
        readCode(5'(1 + 2 * p + 1), v);
        check(v[7:0] == mArea[offOf(b, 2 * p + 1)], "R3 high byte slot", v, mArea[offOf(b, 2 * p + 1)]);
      end
    end
    checkArea("R3 area after pairs");

    // R8: memory port sweep, seen through register codes of bank 2
    for (int i = 0; i < 32; i++) memWrite(i, 8'(8'hC0 ^ i));
    checkArea("R8 mem port");
    regWrite(5'd14, 16'h0020);
    for (int s = 0; s < 8; s++) begin
      readCode(5'(1 + s), v);
      check(v[7:0] == 8'(8'hC0 ^ (8 + s)), "R8 mem to reg view", v, 8'hC0 ^ (8 + s));
    end

    // R5: stack pointer
    regWrite(5'd13, 16'h1235);
    check(gotWarn == 1'b1, "R5 odd warn", gotWarn, 1);
    readCode(5'd13, v); check(v == 16'h1234, "R5 even stack", v, 16'h1234);
    @(negedge clk);
    check(spOddWarn == 1'b0, "R5 warn one cycle", spOddWarn, 0);
    regWrite(5'd13, 16'hFFFE);
    check(gotWarn == 1'b0, "R5 no warn even", gotWarn, 0);
    readCode(5'd13, v); check(v == 16'hFFFE, "R5 even value", v, 16'hFFFE);

    // R6: undefined write codes
    for (int c = 0; c < 32; c++) begin
      if (c == 0 || c >= 18) begin
        regWrite(5'(c), 16'h5A5A);
        check(gotBad == 1'b1, "R6 bad flag", gotBad, 1);
        @(negedge clk);
        check(wrBadCode == 1'b0, "R6 flag one cycle", wrBadCode, 0);
      end
    end
    checkArea("R6 area untouched");
    readCode(5'd14, v); check(v == {8'h00, mStat}, "R6 status untouched", v, mStat);
    readCode(5'd13, v); check(v == 16'hFFFE, "R6 stack untouched", v, 16'hFFFE);
    readCode(5'd16, v); check(v == 16'h000F, "R6 dseg untouched", v, 16'h000F);

    // R9: collisions, bank 0
    regWrite(5'd14, 16'h0000);
    @(negedge clk);
    wrEn = 1'b1; wrCode = 5'd3; wrData = 16'h0077;
    memWe = 1'b1; memAddr = 5'(offOf(0, 2)); memWrData = 8'h99;
    @(negedge clk);
    wrEn = 1'b0; memWe = 1'b0;
    mArea[offOf(0, 2)] = 8'h77;
    memAddr = 5'(offOf(0, 2)); #1;
    check(memRdData == 8'h77, "R9 byte collision", memRdData, 8'h77);
    @(negedge clk);
    wrEn = 1'b1; wrCode = 5'd12; wrData = 16'h3C4D;
    memWe = 1'b1; memAddr = 5'(offOf(0, 7)); memWrData = 8'hEE;
    @(negedge clk);
    wrEn = 1'b0; memWe = 1'b0;
    mArea[offOf(0, 6)] = 8'h4D; mArea[offOf(0, 7)] = 8'h3C;
    checkArea("R9 pair collision");
    @(negedge clk);
    wrEn = 1'b1; wrCode = 5'd4; wrData = 16'h0012;
    memWe = 1'b1; memAddr = 5'(offOf(1, 0)); memWrData = 8'h34;
    @(negedge clk);
    wrEn = 1'b0; memWe = 1'b0;
    mArea[offOf(0, 3)] = 8'h12; mArea[offOf(1, 0)] = 8'h34;
    checkArea("R9 distinct bytes both land");

    // R11: other byte registers
    regWrite(5'd15, 16'hAB5C); readCode(5'd15, v); check(v == 16'h005C, "R11 cseg", v, 16'h005C);
    regWrite(5'd16, 16'hCD03); readCode(5'd16, v); check(v == 16'h0003, "R11 dseg", v, 16'h0003);
    regWrite(5'd17, 16'hEF81); readCode(5'd17, v); check(v == 16'h0081, "R11 mode", v, 16'h0081);
    regWrite(5'd14, 16'h12D7); readCode(5'd14, v); check(v == 16'h00D7, "R11 status", v, 16'h00D7);

    // R10: conditions over zero/carry combinations and tested values
    for (int zc = 0; zc < 4; zc++) begin
      regWrite(5'd14, {8'h00, 1'b0, 1'(zc >> 1), 5'b00000, 1'(zc & 1)});
      for (int sel = 0; sel < 8; sel++) begin
        for (int tv = 0; tv < 3; tv++) begin
          bit z, cy, exp;
          z = 1'(zc >> 1); cy = 1'(zc & 1);
          condSel = 3'(sel);
          condVal = (tv == 0) ? 16'h0000 : ((tv == 1) ? 16'h0100 : 16'h0001);
          #1;
          case (sel)
            0: exp = (condVal != 0);
            1: exp = (condVal == 0);
            2: exp = cy;
            3: exp = !cy;
            4: exp = z;
            5: exp = !z;
            6: exp = !(z || cy);
            default: exp = z || cy;
          endcase
          check(condTrue == exp, "R10 condition", condTrue, exp);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule